// File: doc/BRIEF.md
# Message-Signalled Interrupt Pending/Queued Delivery Gate

This block decides, for each message-signalled interrupt that arrives for a numbered source, whether the interrupt goes on to an interrupt presenter. Each source has a 48-bit vector entry in a small internal table. The entry holds four things:

- a target server field,
- a priority,
- a generation value,
- two state bits: pending (P) and queued (Q).

A trigger is evaluated against the P/Q state of its source. The outcome is one of three: the interrupt is forwarded, it is recorded as queued, or it is dropped. The table is written and read through a simple register port, so that software can program entries and clear P and Q.

The block below the presenter can reject a delivered interrupt. The block records every rejected source number in a bitmap. A resend request then walks that bitmap from the lowest source number upwards. On this path each recorded source is evaluated with both P and Q treated as clear. If Q were honoured here, a queued source would never be delivered again and the system would stall.

A small state machine controls the sequence. It has three states:

- ST_IDLE: waits for work.
- ST_SCAN: takes the lowest recorded source out of the bitmap.
- ST_EVAL: reads the entry, writes back the new P/Q and emits the interrupt.

It has six transitions:

- IDLE_TO_EVAL: an accepted trigger.
- IDLE_TO_SCAN: a pending resend request while the bitmap is non-empty.
- IDLE_STAY: nothing to do. A pending resend request with an empty bitmap is discarded.
- SCAN_TO_EVAL: a recorded source was found.
- EVAL_TO_SCAN: a resend walk is under way and the bitmap still has entries.
- EVAL_TO_IDLE: any other case.

Top module: `msi_pq_gate`

## Requirements
- R1: After reset, irq_valid and busy are 0, every table entry reads 0 and the resend bitmap is empty, so a resend request produces no interrupt.
- R2: A trigger with trig_level=1 accepted in the idle state moves the block to busy on the next cycle. If the stored state {P,Q} is 00 and the priority (entry bits [39:32]) is not 0xFF, the block sets P (bit 24). It raises irq_valid on the second clock edge after the trigger was sampled, together with the entry's generation (bits [15:0]) on irq_gen.
- R3: If the state is 00 and the priority is 0xFF, the block sets Q (bit 16) and emits nothing. irq_valid is never raised with irq_prio equal to 0xFF.
- R4: If the state is 10 (P set, Q clear), the block sets Q and emits nothing.
- R5: If the state is 01 or 11 (Q set), the trigger is dropped and the entry is left unchanged.
- R6: irq_server equals the stored server field (bits [47:40]) shifted right by two, with its upper two bits zero. irq_num equals src_base plus the source number.
- R7: A trigger presented with trig_level=0 changes no entry and emits nothing.
- R8: reject_valid records reject_src in the resend bitmap. A resend request evaluates every recorded source in ascending order with P and Q treated as clear: an unmasked source is emitted and a masked one gets Q set. Each recorded source is removed from the bitmap, so a second request emits nothing.
- R9: irq_valid lasts exactly one cycle. A trigger presented while busy is 1 is ignored.
- R10: A register write (cfg_we) replaces the whole entry at cfg_addr, and has priority over an update to the same entry. cfg_rdata returns the entry at cfg_addr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_valid | input | 1 | Trigger strobe |
| trig_level | input | 1 | Level of the trigger; only 1 starts an attempt |
| trig_src | input | AW | Source number of the trigger |
| reject_valid | input | 1 | Reject pulse from the block below |
| reject_src | input | AW | Source that was rejected |
| resend_req | input | 1 | Request to redeliver all rejected sources |
| src_base | input | NUM_W | Offset added to the source number on output |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | AW | Register entry index |
| cfg_wdata | input | 48 | Entry write data |
| cfg_rdata | output | 48 | Entry read data |
| busy | output | 1 | High while not in the idle state |
| irq_valid | output | 1 | One-cycle interrupt strobe |
| irq_server | output | 8 | Server number with the link pointer stripped |
| irq_prio | output | 8 | Priority |
| irq_gen | output | 16 | Generation value of the delivered entry |
| irq_num | output | NUM_W | Source number plus src_base |

## Verification
The bench builds the block with its defaults, NUM_SRC=16 and NUM_W=12, and uses a src_base of 0x100. With these values the source indices used by the table vectors and the resend walk all fit in one 16-entry table, and the offset shows up clearly on irq_num. Sixteen sources leave room to reject three separate sources in a non-ascending order, so the ascending walk order, the delivery of a source whose P and Q are both set, and the masked case on the resend path can all be seen in one scan. A server field of 0xFF exercises the case where the stripped link pointer bits are both set.

// File: rtl/msi_pq_pkg.sv
package msi_pq_pkg;
    localparam int ENTRY_W    = 48;
    localparam int SERVER_W   = 8;
    localparam int PRIO_W     = 8;
    localparam int GEN_W      = 16;
    localparam int SERVER_LSB = 40;
    localparam int PRIO_LSB   = 32;
    localparam int P_BIT      = 24;
    localparam int Q_BIT      = 16;
    localparam int LINK_W     = 2;
    localparam logic [PRIO_W-1:0] MASK_PRIO = '1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_EVAL = 2'd2
    } gate_state_t;

    function automatic logic [SERVER_W-1:0] ent_server(input logic [ENTRY_W-1:0] e);
        return e[SERVER_LSB +: SERVER_W];
    endfunction

    function automatic logic [PRIO_W-1:0] ent_prio(input logic [ENTRY_W-1:0] e);
        return e[PRIO_LSB +: PRIO_W];
    endfunction

    function automatic logic [GEN_W-1:0] ent_gen(input logic [ENTRY_W-1:0] e);
        return e[GEN_W-1:0];
    endfunction
endpackage

// File: rtl/msi_vec_table.sv
module msi_vec_table
    import msi_pq_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int AW      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [AW-1:0]      cfg_addr,
    input  logic [ENTRY_W-1:0] cfg_wdata,
    input  logic               upd_we,
    input  logic [AW-1:0]      upd_addr,
    input  logic [ENTRY_W-1:0] upd_wdata,
    input  logic [AW-1:0]      rda_addr,
    output logic [ENTRY_W-1:0] rda_data,
    input  logic [AW-1:0]      rdb_addr,
    output logic [ENTRY_W-1:0] rdb_data
);
    logic [ENTRY_W-1:0] cells [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
        logic [ENTRY_W-1:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else if (cfg_we && (cfg_addr == AW'(g))) begin
                cell_q <= cfg_wdata;
            end else if (upd_we && (upd_addr == AW'(g))) begin
                cell_q <= upd_wdata;
            end
        end
        assign cells[g] = cell_q;
    end

    always_comb begin
        rda_data = '0;
        rdb_data = '0;
        if (int'(rda_addr) < NUM_SRC) rda_data = cells[rda_addr];
        if (int'(rdb_addr) < NUM_SRC) rdb_data = cells[rdb_addr];
    end
endmodule

// File: rtl/msi_resend_map.sv
module msi_resend_map #(
    parameter int NUM_SRC = 16,
    parameter int AW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [AW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [AW-1:0] clr_idx,
    output logic          any,
    output logic [AW-1:0] lowest
);
    logic [NUM_SRC-1:0] bits_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bits_q[g] <= 1'b0;
            end else if (set_en && (set_idx == AW'(g))) begin
                bits_q[g] <= 1'b1;
            end else if (clr_en && (clr_idx == AW'(g))) begin
                bits_q[g] <= 1'b0;
            end
        end
    end

    assign any = |bits_q;

    always_comb begin
        lowest = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (bits_q[i]) lowest = AW'(i);
        end
    end
endmodule

// File: rtl/msi_pq_decide.sv
module msi_pq_decide
    import msi_pq_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  logic               resend_path,
    output logic               emit,
    output logic               change,
    output logic [ENTRY_W-1:0] next_entry
);
    logic [1:0] pq_eff;
    logic       masked;

    always_comb begin
        pq_eff     = resend_path ? 2'b00 : {entry[P_BIT], entry[Q_BIT]};
        masked     = (ent_prio(entry) == MASK_PRIO);
        emit       = 1'b0;
        change     = 1'b0;
        next_entry = entry;
        unique case (pq_eff)
            2'b00: begin
                change = 1'b1;
                if (masked) begin
                    next_entry[Q_BIT] = 1'b1;
                end else begin
                    next_entry[P_BIT] = 1'b1;
                    emit              = 1'b1;
                end
            end
            2'b10: begin
                change            = 1'b1;
                next_entry[Q_BIT] = 1'b1;
            end
            default: begin
                change = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/msi_pq_gate.sv
module msi_pq_gate
    import msi_pq_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_W   = 12,
    localparam int AW     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig_valid,
    input  logic                trig_level,
    input  logic [AW-1:0]       trig_src,
    input  logic                reject_valid,
    input  logic [AW-1:0]       reject_src,
    input  logic                resend_req,
    input  logic [NUM_W-1:0]    src_base,
    input  logic                cfg_we,
    input  logic [AW-1:0]       cfg_addr,
    input  logic [ENTRY_W-1:0]  cfg_wdata,
    output logic [ENTRY_W-1:0]  cfg_rdata,
    output logic                busy,
    output logic                irq_valid,
    output logic [SERVER_W-1:0] irq_server,
    output logic [PRIO_W-1:0]   irq_prio,
    output logic [GEN_W-1:0]    irq_gen,
    output logic [NUM_W-1:0]    irq_num
);
    gate_state_t        state_q, state_d;
    logic [AW-1:0]      cur_src_q;
    logic               cur_resend_q;
    logic               rs_pend_q;
    logic [ENTRY_W-1:0] cur_entry;
    logic               dec_emit, dec_change;
    logic [ENTRY_W-1:0] dec_next;
    logic               map_any;
    logic [AW-1:0]      map_lowest;
    logic               trig_take;
    logic               scan_take;

    assign trig_take = (state_q == ST_IDLE) && trig_valid && trig_level;
    assign scan_take = (state_q == ST_SCAN) && map_any;
    assign busy      = (state_q != ST_IDLE);

    msi_vec_table #(.NUM_SRC(NUM_SRC), .AW(AW)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .upd_we   ((state_q == ST_EVAL) && dec_change),
        .upd_addr (cur_src_q),
        .upd_wdata(dec_next),
        .rda_addr (cfg_addr),
        .rda_data (cfg_rdata),
        .rdb_addr (cur_src_q),
        .rdb_data (cur_entry)
    );

    msi_resend_map #(.NUM_SRC(NUM_SRC), .AW(AW)) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (reject_valid),
        .set_idx(reject_src),
        .clr_en (scan_take),
        .clr_idx(map_lowest),
        .any    (map_any),
        .lowest (map_lowest)
    );

    msi_pq_decide u_decide (
        .entry      (cur_entry),
        .resend_path(cur_resend_q),
        .emit       (dec_emit),
        .change     (dec_change),
        .next_entry (dec_next)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_take) begin
                    state_d = ST_EVAL;                     // IDLE_TO_EVAL
                end else if (rs_pend_q && map_any) begin
                    state_d = ST_SCAN;                     // IDLE_TO_SCAN
                end
            end
            ST_SCAN: begin
                state_d = map_any ? ST_EVAL : ST_IDLE;     // SCAN_TO_EVAL
            end
            ST_EVAL: begin
                state_d = (cur_resend_q && map_any) ? ST_SCAN : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // working registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_src_q    <= '0;
            cur_resend_q <= 1'b0;
            rs_pend_q    <= 1'b0;
            irq_valid    <= 1'b0;
            irq_server   <= '0;
            irq_prio     <= '0;
            irq_gen      <= '0;
            irq_num      <= '0;
        end else begin
            irq_valid <= 1'b0;
            if (resend_req) begin
                rs_pend_q <= 1'b1;
            end else if (state_q == ST_IDLE && !trig_take) begin
                rs_pend_q <= 1'b0;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (trig_take) begin
                        cur_src_q    <= trig_src;
                        cur_resend_q <= 1'b0;
                    end else if (rs_pend_q && map_any) begin
                        cur_resend_q <= 1'b1;
                    end
                end
                ST_SCAN: begin
                    if (map_any) begin
                        cur_src_q    <= map_lowest;
                        cur_resend_q <= 1'b1;
                    end
                end
                ST_EVAL: begin
                    if (dec_emit) begin
                        irq_valid  <= 1'b1;
                        irq_server <= ent_server(cur_entry) >> LINK_W;
                        irq_prio   <= ent_prio(cur_entry);
                        irq_gen    <= ent_gen(cur_entry);
                        irq_num    <= src_base + NUM_W'(cur_src_q);
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/msi_pq_gate_chk.sv
module msi_pq_gate_chk
    import msi_pq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                trig_valid,
    input logic                trig_level,
    input logic                busy,
    input logic                irq_valid,
    input logic [SERVER_W-1:0] irq_server,
    input logic [PRIO_W-1:0]   irq_prio
);
    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);

    // R6
    server_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_server[SERVER_W-1 -: LINK_W] == '0));

    // R3
    masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_prio != MASK_PRIO));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trig_valid && trig_level) |=> busy);

    // R2
    emit_after_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_valid) |-> $past(busy));
endmodule

bind msi_pq_gate msi_pq_gate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_valid(trig_valid),
    .trig_level(trig_level),
    .busy      (busy),
    .irq_valid (irq_valid),
    .irq_server(irq_server),
    .irq_prio  (irq_prio)
);

// File: tb/tb_msi_pq_gate.sv
module tb_msi_pq_gate;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 16;
    localparam int NW   = 12;
    localparam int AW   = 4;
    localparam logic [NW-1:0] BASE = 12'h100;
    localparam int NV = 8;

    localparam logic [47:0] PRE [NV] = '{
        48'h2C05_0000_00AB, 48'h10FF_0000_1234, 48'h2C05_0100_00AB, 48'h2C05_0001_00AB,
        48'h2C05_0101_00AB, 48'h2C05_0000_00AB, 48'hFF00_0000_0001, 48'h10FF_0100_0000};
    localparam logic LVL  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic EMIT [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam logic [47:0] POST [NV] = '{
        48'h2C05_0100_00AB, 48'h10FF_0001_1234, 48'h2C05_0101_00AB, 48'h2C05_0001_00AB,
        48'h2C05_0101_00AB, 48'h2C05_0000_00AB, 48'hFF00_0100_0001, 48'h10FF_0101_0000};
    localparam logic [7:0] XSRV [NV] = '{8'h0B, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h3F, 8'h00};

    logic clk = 0, rst_n = 0;
    logic trig_valid = 0, trig_level = 0, reject_valid = 0, resend_req = 0, cfg_we = 0;
    logic [AW-1:0] trig_src = '0, reject_src = '0, cfg_addr = '0;
    logic [NW-1:0] src_base = BASE;
    logic [47:0] cfg_wdata = '0, cfg_rdata;
    logic busy, irq_valid;
    logic [7:0] irq_server, irq_prio;
    logic [15:0] irq_gen;
    logic [NW-1:0] irq_num;

    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_pq_gate #(.NUM_SRC(NSRC), .NUM_W(NW)) dut (
        .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_level(trig_level),
        .trig_src(trig_src), .reject_valid(reject_valid), .reject_src(reject_src),
        .resend_req(resend_req), .src_base(src_base), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy), .irq_valid(irq_valid),
        .irq_server(irq_server), .irq_prio(irq_prio), .irq_gen(irq_gen), .irq_num(irq_num));

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [47:0] d);
        @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [47:0] d);
        cfg_addr = a; #1; d = cfg_rdata;
    endtask

    task automatic trig(input logic [AW-1:0] s, input logic lvl);
        @(negedge clk); trig_valid = 1; trig_level = lvl; trig_src = s;
        @(negedge clk); trig_valid = 0; trig_level = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [47:0] d;
        int emits;
        logic [NW-1:0] order [4];
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "irq_valid", 64'(irq_valid), 0);
        check("R1", "busy", 64'(busy), 0);
        rd(4'd9, d); check("R1", "entry", 64'(d), 0);
        rst_n = 1;
        @(negedge clk); resend_req = 1; @(negedge clk); resend_req = 0;
        emits = 0;
        repeat (6) begin @(negedge clk); if (irq_valid) emits++; end
        check("R1", "resend on empty map", 64'(emits), 0);

        // vector table: R2..R7
        for (int i = 0; i < NV; i++) begin
            logic [AW-1:0] s;
            string tag;
            s = AW'(i + 2);
            tag = (i == 0 || i == 6) ? "R2" : (i == 1) ? "R3" : (i == 2 || i == 7) ? "R4" :
                  (i == 5) ? "R7" : "R5";
            wr(s, PRE[i]);
            @(negedge clk); trig_valid = 1; trig_level = LVL[i]; trig_src = s;
            @(negedge clk); trig_valid = 0; trig_level = 0;
            @(negedge clk);
            check(tag, "emit", 64'(irq_valid), 64'(EMIT[i]));
            if (EMIT[i]) begin
                check("R6", "server", 64'(irq_server), 64'(XSRV[i]));
                check(tag, "prio", 64'(irq_prio), 64'(PRE[i][39:32]));
                check(tag, "gen", 64'(irq_gen), 64'(PRE[i][15:0]));
                check("R6", "num", 64'(irq_num), 64'(BASE + NW'(s)));
            end
            rd(s, d); check(tag, "entry after", 64'(d), 64'(POST[i]));
            @(negedge clk);
            check("R9", "pulse ends", 64'(irq_valid), 0);
        end

        // R9 trigger while busy is ignored
        wr(4'd12, 48'h2C05_0000_0000);
        wr(4'd13, 48'h2C05_0000_0000);
        @(negedge clk); trig_valid = 1; trig_level = 1; trig_src = 4'd12;
        @(negedge clk); check("R9", "busy", 64'(busy), 1); trig_src = 4'd13;
        @(negedge clk); trig_valid = 0; trig_level = 0;
        repeat (3) @(negedge clk);
        rd(4'd13, d); check("R9", "busy trigger ignored", 64'(d), 64'h2C05_0000_0000);

        // R10 write over, readback
        wr(4'd12, 48'h1234_5678_9ABC);
        rd(4'd12, d); check("R10", "readback", 64'(d), 64'h1234_5678_9ABC);

        // R8 reject then resend walk
        wr(4'd3, 48'h2C05_0101_00AB);
        wr(4'd5, 48'h3007_0100_0011);
        wr(4'd7, 48'h10FF_0001_0000);
        @(negedge clk); reject_valid = 1; reject_src = 4'd7;
        @(negedge clk); reject_src = 4'd5;
        @(negedge clk); reject_src = 4'd3;
        @(negedge clk); reject_valid = 0; resend_req = 1;
        @(negedge clk); resend_req = 0;
        emits = 0;
        repeat (14) begin
            @(negedge clk);
            if (irq_valid) begin
                if (emits < 4) order[emits] = irq_num;
                emits++;
            end
        end
        check("R8", "resend emit count", 64'(emits), 2);
        check("R8", "first emitted", 64'(order[0]), 64'(BASE + 12'd3));
        check("R8", "second emitted", 64'(order[1]), 64'(BASE + 12'd5));
        rd(4'd7, d); check("R8", "masked entry", 64'(d), 64'h10FF_0001_0000);
        rd(4'd3, d); check("R8", "entry 3", 64'(d), 64'h2C05_0101_00AB);
        @(negedge clk); resend_req = 1; @(negedge clk); resend_req = 0;
        emits = 0;
        repeat (8) begin @(negedge clk); if (irq_valid) emits++; end
        check("R8", "map cleared", 64'(emits), 0);

        // R5 normal path on P/Q=11 drops
        trig(4'd3, 1'b1);
        emits = 0;
        repeat (3) begin @(negedge clk); if (irq_valid) emits++; end
        check("R5", "normal drop after resend", 64'(emits), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule